// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with an 8-bit up counter that advances on every cycle in which a source-clock enable is high, provided the watchdog is running. Software must service it by writing a clear code while the count lies in the upper half of its range. The block raises a single-cycle interrupt request in two cases. The first is when the counter wraps past its maximum. The second is when a clear arrives too early, while the count is still in the lower half. Each cause sets its own sticky status flag. Reading the status register clears both flags.

Stopping the watchdog takes two steps, so that a stray write cannot switch it off. Software first drops the enable bit in the control register, then writes a dedicated stop code to the code register. Either step alone leaves the counter running. A stop forces the count to zero. Setting the enable bit again restarts counting from zero and needs no code. The live count is exposed so that software can confirm the counter is advancing.

Top module: `wdg_window_top`

## Requirements
- R1: While running, each cycle with `tickEn` high and no accepted code raises `countOut` by one.
- R2: A tick while `countOut` is 0xFF wraps the count to 0x00, sets the overflow flag (status bit 2) and pulses `irqOut`.
- R3: Writing 0x4E to the code register while running with `countOut` at 0x80 or above sets the count to 0x00 and raises neither a flag nor `irqOut`; this clear also takes precedence over a tick arriving in the same cycle.
- R4: Writing 0x4E while running with `countOut` below 0x80 sets the early-clear flag (status bit 1), pulses `irqOut` and leaves the count unchanged.
- R5: After reset the enable bit `enableOut` is 1, the watchdog runs (status bit 0 = 1), `countOut` is 0x00, both flags are 0 and `irqOut` is 0.
- R6: The watchdog stops only when 0xB1 is written to the code register while the enable bit is already 0. Writing 0xB1 with the enable bit at 1, or clearing the enable bit without the code, leaves it running. Status bit 0 shows the running state.
- R7: While stopped, `countOut` stays 0x00, ticks are ignored, and a 0x4E write sets no flag and raises no interrupt.
- R8: Writing 1 to the enable bit restarts a stopped watchdog without a code write, and counting resumes from 0x00.
- R9: If a valid stop coincides with a tick at count 0xFF, the watchdog stops, the count becomes 0x00, and neither the overflow flag nor `irqOut` is raised.
- R10: A cycle with `statusRdEn` high clears both flags at the next edge. A flag whose event occurs in the same cycle as the read stays set.
- R11: Code values other than 0x4E and 0xB1 have no effect on the count, the flags or `irqOut`.
- R12: `irqOut` is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Source-clock enable; one count step per high cycle |
| ctrlWrEn | input | 1 | Write strobe for the enable bit |
| ctrlWrData | input | 1 | Value written to the enable bit |
| codeWrEn | input | 1 | Write strobe for the code register |
| codeWrData | input | 8 | Code value (0x4E clear, 0xB1 stop) |
| statusRdEn | input | 1 | Status read strobe; clears both flags |
| countOut | output | 8 | Live counter value |
| statusOut | output | 3 | {overflow flag, early-clear flag, running} |
| enableOut | output | 1 | Current enable bit |
| irqOut | output | 1 | Single-cycle interrupt request |

## Verification
Every result is registered once. A stimulus applied in cycle N therefore changes `countOut`, `statusOut`, `enableOut` and `irqOut` right after the edge that ends cycle N, and the interrupt falls again one edge later. The bench drives each stimulus for exactly one cycle from the falling edge. It samples at the next falling edge, half a period after the updating edge. It then runs one more idle step wherever the fall of the pulse or the clearing by a read must be seen. Both window boundaries (0x7F and 0x80) and the overflow boundary are reached by counting up tick by tick, so the expected count is always known in the bench.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic zeroCnt;
    logic incCnt;
  } cnt_strb_t;
endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int WIN_START = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strb_t        strb,
  output logic [CNT_W-1:0] cnt,
  output logic             inWindow,
  output logic             atMax
);
  localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(WIN_START);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.zeroCnt) cnt <= '0;
    else if (strb.incCnt)  cnt <= cnt + 1'b1;
  end

  assign inWindow = (cnt >= WIN_LO);
  assign atMax    = &cnt;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCnt && !strb.zeroCnt) |=> (cnt == $past(cnt) + 1'b1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incCnt && !strb.zeroCnt) |=> $stable(cnt)); // R11
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int                CNT_W    = 8,
  parameter int                CODE_W   = 8,
  parameter logic [CODE_W-1:0] CLR_CODE = 8'h4E,
  parameter logic [CODE_W-1:0] DIS_CODE = 8'hB1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              ctrlWrEn,
  input  logic              ctrlWrData,
  input  logic              codeWrEn,
  input  logic [CODE_W-1:0] codeWrData,
  input  logic              statusRdEn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              inWindow,
  input  logic              atMax,
  output cnt_strb_t         strb,
  output logic              running,
  output logic              enBit,
  output logic              ovfFlag,
  output logic              earlyFlag,
  output logic              irq
);
  logic enWrOne, disableReq, clearReq, clearOk, clearBad, ovfEvt;

  assign enWrOne    = ctrlWrEn && ctrlWrData;
  // Stop needs the enable bit already low and no simultaneous re-enable
  assign disableReq = running && codeWrEn && (codeWrData == DIS_CODE) && !enBit && !enWrOne;
  assign clearReq   = running && codeWrEn && (codeWrData == CLR_CODE);
  assign clearOk    = clearReq && inWindow;
  assign clearBad   = clearReq && !inWindow;
  // Stop and in-window clear both pre-empt a wrap
  assign ovfEvt     = running && tickEn && atMax && !disableReq && !clearOk;

  assign strb.zeroCnt = disableReq || clearOk || !running;
  assign strb.incCnt  = running && tickEn && !disableReq && !clearOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b1;
      enBit     <= 1'b1;
      ovfFlag   <= 1'b0;
      earlyFlag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (enWrOne)         running <= 1'b1;
      else if (disableReq) running <= 1'b0;
      if (ctrlWrEn) enBit <= ctrlWrData;
      if (ovfEvt)          ovfFlag <= 1'b1;
      else if (statusRdEn) ovfFlag <= 1'b0;
      if (clearBad)        earlyFlag <= 1'b1;
      else if (statusRdEn) earlyFlag <= 1'b0;
      irq <= ovfEvt || clearBad;
    end
  end

  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (cntIn == '0)); // R7
  AST_CODE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (running && enBit && !(ctrlWrEn && !ctrlWrData)) |=> running); // R6
  AST_STOP_BEATS_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (disableReq && tickEn && atMax) |=> (!irq && !running)); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ovfFlag || earlyFlag)); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statusRdEn && !tickEn && !codeWrEn) |=> (!ovfFlag && !earlyFlag)); // R10
endmodule

// File: rtl/wdg_window_top.sv
module wdg_window_top
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int CODE_W    = 8,
  parameter int WIN_START = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              ctrlWrEn,
  input  logic              ctrlWrData,
  input  logic              codeWrEn,
  input  logic [CODE_W-1:0] codeWrData,
  input  logic              statusRdEn,
  output logic [CNT_W-1:0]  countOut,
  output logic [2:0]        statusOut,
  output logic              enableOut,
  output logic              irqOut
);
  cnt_strb_t strb;
  logic inWindow, atMax, running, ovfFlag, earlyFlag;

  wdg_ctrl #(.CNT_W(CNT_W), .CODE_W(CODE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .codeWrEn(codeWrEn), .codeWrData(codeWrData), .statusRdEn(statusRdEn),
    .cntIn(countOut), .inWindow(inWindow), .atMax(atMax),
    .strb(strb), .running(running), .enBit(enableOut),
    .ovfFlag(ovfFlag), .earlyFlag(earlyFlag), .irq(irqOut)
  );

  wdg_datapath #(.CNT_W(CNT_W), .WIN_START(WIN_START)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cnt(countOut), .inWindow(inWindow), .atMax(atMax)
  );

  assign statusOut = {ovfFlag, earlyFlag, running};
endmodule

// File: tb/test_wdg_window_top.sv
module test_wdg_window_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic tickEn = 0, ctrlWrEn = 0, ctrlWrData = 0, codeWrEn = 0, statusRdEn = 0;
  logic [7:0] codeWrData = '0;
  logic [7:0] countOut;
  logic [2:0] statusOut;
  logic enableOut, irqOut;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdg_window_top i_wdg_window_top (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .codeWrEn(codeWrEn), .codeWrData(codeWrData),
    .statusRdEn(statusRdEn), .countOut(countOut), .statusOut(statusOut),
    .enableOut(enableOut), .irqOut(irqOut)
  );

  typedef struct packed {
    logic tick; logic cw; logic [7:0] code; logic ew; logic ed; logic rd;
    logic [7:0] eCnt; logic [2:0] eSt; logic eIrq; logic eEn; logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h01,3'b001,1'b0,1'b1, 4'd1 },  // R1
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h02,3'b001,1'b0,1'b1, 4'd1 },  // R1
    '{1'b0,1'b1,8'h55,1'b0,1'b0,1'b0, 8'h02,3'b001,1'b0,1'b1, 4'd11},  // R11
    '{1'b0,1'b1,8'h4E,1'b0,1'b0,1'b0, 8'h02,3'b011,1'b1,1'b1, 4'd4 },  // R4
    '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h02,3'b011,1'b0,1'b1, 4'd12},  // R12
    '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 8'h02,3'b001,1'b0,1'b1, 4'd10},  // R10
    '{1'b0,1'b1,8'hB1,1'b0,1'b0,1'b0, 8'h02,3'b001,1'b0,1'b1, 4'd6 },  // R6
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 8'h02,3'b001,1'b0,1'b0, 4'd6 },  // R6
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h03,3'b001,1'b0,1'b0, 4'd6 },  // R6
    '{1'b0,1'b1,8'hB1,1'b0,1'b0,1'b0, 8'h00,3'b000,1'b0,1'b0, 4'd6 },  // R6
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h00,3'b000,1'b0,1'b0, 4'd7 },  // R7
    '{1'b0,1'b1,8'h4E,1'b0,1'b0,1'b0, 8'h00,3'b000,1'b0,1'b0, 4'd7 },  // R7
    '{1'b0,1'b0,8'h00,1'b1,1'b1,1'b0, 8'h00,3'b001,1'b0,1'b1, 4'd8 },  // R8
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h01,3'b001,1'b0,1'b1, 4'd8 }   // R8
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic [7:0] c, input logic [2:0] s, input logic i, input logic e);
    chk(req, "count", countOut, c);
    chk(req, "status", {5'b0, statusOut}, {5'b0, s});
    chk(req, "irq", {7'b0, irqOut}, {7'b0, i});
    chk(req, "enable", {7'b0, enableOut}, {7'b0, e});
  endtask

  // Drive one cycle from a falling edge; sampling happens at the next falling edge
  task automatic step(input logic t, input logic cw, input logic [7:0] code,
                      input logic ew, input logic ed, input logic rd);
    tickEn = t; codeWrEn = cw; codeWrData = code;
    ctrlWrEn = ew; ctrlWrData = ed; statusRdEn = rd;
    @(negedge clk);
    tickEn = 0; codeWrEn = 0; codeWrData = '0; ctrlWrEn = 0; ctrlWrData = 0; statusRdEn = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish();
  end

  initial begin
    repeat (2) @(negedge clk);
    chkAll("R5", 8'h00, 3'b001, 1'b0, 1'b1);
    rstN = 1;
    @(negedge clk);
    chkAll("R5", 8'h00, 3'b001, 1'b0, 1'b1);

    for (int v = 0; v < NV; v++) begin
      step(VECS[v].tick, VECS[v].cw, VECS[v].code, VECS[v].ew, VECS[v].ed, VECS[v].rd);
      chkAll($sformatf("R%0d", VECS[v].req), VECS[v].eCnt, VECS[v].eSt, VECS[v].eIrq, VECS[v].eEn);
    end

    // R4 boundary: early clear at 0x7F keeps the count
    ticks(126);
    chk("R1", "count", countOut, 8'h7F);
    step(0, 1, 8'h4E, 0, 0, 0);
    chkAll("R4", 8'h7F, 3'b011, 1'b1, 1'b1);
    step(0, 0, 8'h00, 0, 0, 1);
    chkAll("R10", 8'h7F, 3'b001, 1'b0, 1'b1);
    // R3 boundary: clear at 0x80 is accepted
    ticks(1);
    step(0, 1, 8'h4E, 0, 0, 0);
    chkAll("R3", 8'h00, 3'b001, 1'b0, 1'b1);
    // R3: in-window clear wins over a tick at 0xFF
    ticks(255);
    step(1, 1, 8'h4E, 0, 0, 0);
    chkAll("R3", 8'h00, 3'b001, 1'b0, 1'b1);

    // R2 overflow
    ticks(255);
    chk("R2", "count", countOut, 8'hFF);
    step(1, 0, 8'h00, 0, 0, 0);
    chkAll("R2", 8'h00, 3'b101, 1'b1, 1'b1);
    step(0, 0, 8'h00, 0, 0, 0);
    chkAll("R12", 8'h00, 3'b101, 1'b0, 1'b1);
    step(0, 0, 8'h00, 0, 0, 1);
    chkAll("R10", 8'h00, 3'b001, 1'b0, 1'b1);

    // R10: event in the same cycle as a read stays flagged
    ticks(3);
    step(0, 1, 8'h4E, 0, 0, 1);
    chkAll("R10", 8'h03, 3'b011, 1'b1, 1'b1);
    step(0, 0, 8'h00, 0, 0, 1);
    chkAll("R10", 8'h03, 3'b001, 1'b0, 1'b1);

    // R9: stop coinciding with a wrap
    step(0, 0, 8'h00, 1, 0, 0);
    ticks(252);
    chk("R9", "count", countOut, 8'hFF);
    step(1, 1, 8'hB1, 0, 0, 0);
    chkAll("R9", 8'h00, 3'b000, 1'b0, 1'b0);
    step(0, 0, 8'h00, 0, 0, 0);
    chkAll("R9", 8'h00, 3'b000, 1'b0, 1'b0);

    // R8: restart and count again
    step(0, 0, 8'h00, 1, 1, 0);
    ticks(2);
    chkAll("R8", 8'h02, 3'b001, 1'b0, 1'b1);

    finish();
  end
endmodule